// File: doc/BRIEF.md
# Serial Port FIFO, Status and Interrupt Controller

This block sits between a processor bus and a serial line engine. It holds outgoing characters in a transmit queue and incoming characters in a receive queue. Software sees five word-aligned registers: a transmit data port, a receive data port, a control word, a status word and a threshold word. The shift engine and the baud generator live outside the block. The engine takes transmit bytes through a valid/take handshake and delivers received bytes, with their parity and framing error marks, through a one-cycle push strobe.

A single interrupt line combines two conditions, and software enables each one on its own. The receive condition fires when enough characters are waiting. The transmit condition fires when the transmit queue has drained to a low level. Error conditions are sticky and stay set until software asserts the clear-error control bit. Each queue has a flush control bit. The queue depth is a parameter: 64 by default, 128 as the alternative.

Bus reads return data combinationally in the cycle they are presented. Bus writes, and the pop caused by reading the receive port, take effect at the next rising clock edge.

Top module: `ser_fifo_ctl`

## Requirements
- R1: After reset, the status word reads 0x0050_0000 (receive empty at bit 20, transmit empty at bit 22) and the threshold word reads 0x0000_2001 with the default depth of 64. At the same time `irq` and `tx_valid` are 0.
- R2: Bytes written to offset 0x00 reach the engine on `tx_data`/`tx_valid` in write order. A byte leaves the queue at each rising edge where `tx_valid` and `tx_take` are both 1.
- R3: Bytes pushed by the engine with `rx_push` are returned in arrival order in bits [7:0] of offset 0x04. Each read of 0x04 pops one byte.
- R4: A read of 0x04 while the receive queue is empty returns 0 and changes no queue state.
- R5: Status bit 21 is 1 exactly when the transmit queue holds DEPTH bytes, and status bit 22 is 1 exactly when it holds none.
- R6: Status bit 25 mirrors `line_busy`. Transmission is complete only when bit 22 is 1 and bit 25 is 0.
- R7: A write to 0x00 while the transmit queue is full discards the byte and sets status bit 18. Bit 18 stays set until control bit 24 is written as 1.
- R8: A received byte pushed with `rx_par_err` sets status bit 16, and one pushed with `rx_frm_err` sets status bit 17. Both bits are sticky and are cleared by control bit 24.
- R9: An `rx_push` while the receive queue holds DEPTH bytes is dropped, and the bytes already stored are kept.
- R10: With control bit 27 set, `irq` is 1 whenever the receive count is at or above threshold bits [7:0].
- R11: With control bit 28 set, `irq` is 1 whenever the transmit count is at or below threshold bits [15:8]. With both enable bits at 0, `irq` is 0.
- R12: Control bit 22 empties the transmit queue and control bit 23 empties the receive queue. Each takes effect at the edge that writes it, and the queue stays empty, ignoring pushes, while the bit remains 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at 0x04) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | Transmit queue has a byte for the engine |
| tx_data | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine takes the byte on `tx_data` |
| line_busy | input | 1 | Engine is still shifting a character out |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Received byte had a parity error |
| rx_frm_err | input | 1 | Received byte had a framing error |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench fills the transmit queue to exactly DEPTH and then writes once more. A design that accepted the extra byte would send an unexpected character to the scoreboard, and one that dropped the error flag after draining would read status bit 18 as 0. Overfilling the receive queue by one checks that the last byte is dropped and not written over the oldest one. Reading an empty receive port checks that a design which moved its read pointer on an empty pop returns garbage afterwards. Both interrupt conditions are probed right at their threshold boundaries, where an off-by-one comparison would shift the edge. The flush bits are exercised with writes made while the flush is held, which catches a queue that empties only once instead of staying empty.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [4:0] OFS_TXD  = 5'h00;
  localparam logic [4:0] OFS_RXD  = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_THR  = 5'h10;

  localparam int C_TX_FLUSH = 22;
  localparam int C_RX_FLUSH = 23;
  localparam int C_CLR_ERR  = 24;
  localparam int C_RX_IE    = 27;
  localparam int C_TX_IE    = 28;
  localparam logic [31:0] CTRL_MASK = 32'h19C0_0000;

  localparam int S_PERR = 16;
  localparam int S_FERR = 17;
  localparam int S_WERR = 18;
  localparam int S_RXE  = 20;
  localparam int S_TXF  = 21;
  localparam int S_TXE  = 22;
  localparam int S_BUSY = 25;

  function automatic logic rx_level_hit(logic [8:0] cnt, logic [7:0] thr);
    return cnt >= {1'b0, thr};
  endfunction

  function automatic logic tx_level_hit(logic [8:0] cnt, logic [7:0] thr);
    return cnt <= {1'b0, thr};
  endfunction

  function automatic logic [31:0] pack_status(logic [2:0] errs, logic rxe,
                                               logic txf, logic txe, logic busy);
    logic [31:0] s;
    s = '0;
    s[S_PERR] = errs[0];
    s[S_FERR] = errs[1];
    s[S_WERR] = errs[2];
    s[S_RXE]  = rxe;
    s[S_TXF]  = txf;
    s[S_TXE]  = txe;
    s[S_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/sfc_sticky.sv
module sfc_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (clr) q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sfc_irq.sv
module sfc_irq (
  input  logic [8:0] rx_cnt,
  input  logic [8:0] tx_cnt,
  input  logic [7:0] rx_thr,
  input  logic [7:0] tx_thr,
  input  logic       rx_en,
  input  logic       tx_en,
  output logic       rx_irq,
  output logic       tx_irq,
  output logic       irq
);
  import sfc_pkg::*;
  assign rx_irq = rx_en && rx_level_hit(rx_cnt, rx_thr);
  assign tx_irq = tx_en && tx_level_hit(tx_cnt, tx_thr);
  assign irq    = rx_irq || tx_irq;
endmodule

// File: rtl/ser_fifo_ctl.sv
module ser_fifo_ctl #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_take,
  input  logic        line_busy,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_par_err,
  input  logic        rx_frm_err,
  output logic        irq
);
  import sfc_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [15:0] THR_RST = {8'(DEPTH / 2), 8'd1};

  logic [31:0] ctrl_q;
  logic [15:0] thr_q;

  // named events
  logic tx_wr_evt, rx_rd_evt, ctrl_wr_evt, thr_wr_evt, cfg_wr_evt;
  logic tx_flush, rx_flush, clr_evt, tx_pop_evt;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [8:0] tx_cnt9, rx_cnt9;
  logic [7:0] rx_head;
  logic [2:0] err_set, err_q;
  logic werr_q;
  logic rx_irq, tx_irq;

  assign tx_wr_evt   = bus_wr && (bus_addr == OFS_TXD);
  assign rx_rd_evt   = bus_rd && (bus_addr == OFS_RXD);
  assign ctrl_wr_evt = bus_wr && (bus_addr == OFS_CTRL);
  assign thr_wr_evt  = bus_wr && (bus_addr == OFS_THR);
  assign cfg_wr_evt  = ctrl_wr_evt || thr_wr_evt;

  assign tx_flush = ctrl_q[C_TX_FLUSH] || (ctrl_wr_evt && bus_wdata[C_TX_FLUSH]);
  assign rx_flush = ctrl_q[C_RX_FLUSH] || (ctrl_wr_evt && bus_wdata[C_RX_FLUSH]);
  assign clr_evt  = ctrl_q[C_CLR_ERR]  || (ctrl_wr_evt && bus_wdata[C_CLR_ERR]);
  assign tx_pop_evt = tx_valid && tx_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= THR_RST;
    end else begin
      if (ctrl_wr_evt) ctrl_q <= bus_wdata & CTRL_MASK;
      if (thr_wr_evt)  thr_q  <= bus_wdata[15:0];
    end
  end

  sfc_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr_evt), .din(bus_wdata[7:0]),
    .pop(tx_take), .head(tx_data),
    .empty(tx_empty), .full(tx_full), .count(tx_cnt)
  );

  sfc_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_byte),
    .pop(rx_rd_evt), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  assign tx_valid = !tx_empty;
  assign tx_cnt9  = 9'(tx_cnt);
  assign rx_cnt9  = 9'(rx_cnt);

  assign err_set = {tx_wr_evt && tx_full,
                    rx_push && rx_frm_err,
                    rx_push && rx_par_err};

  sfc_sticky #(.N(3)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(clr_evt), .q(err_q)
  );
  assign werr_q = err_q[2];

  sfc_irq u_irq (
    .rx_cnt(rx_cnt9), .tx_cnt(tx_cnt9),
    .rx_thr(thr_q[7:0]), .tx_thr(thr_q[15:8]),
    .rx_en(ctrl_q[C_RX_IE]), .tx_en(ctrl_q[C_TX_IE]),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_RXD:  bus_rdata = {24'h0, rx_head};
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_STAT: bus_rdata = pack_status(err_q, rx_empty, tx_full, tx_empty, line_busy);
      OFS_THR:  bus_rdata = {16'h0, thr_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ser_fifo_ctl_chk.sv
module ser_fifo_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_wr_evt,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       werr_q,
  input logic       clr_evt,
  input logic       tx_flush,
  input logic       rx_flush,
  input logic       rx_rd_evt,
  input logic       rx_empty,
  input logic       rx_push,
  input logic       rx_ie,
  input logic [8:0] rx_cnt9,
  input logic [7:0] rx_thr,
  input logic       cfg_wr_evt,
  input logic       irq
);
  p_werr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && tx_full && !clr_evt) |=> werr_q);

  p_werr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (werr_q && !clr_evt) |=> werr_q);

  p_werr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !werr_q);

  p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty);

  p_rx_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_empty);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_evt && rx_empty && !rx_push) |=> rx_empty);

  p_rx_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && (rx_cnt9 >= {1'b0, rx_thr}) && !rx_rd_evt && !rx_flush && !cfg_wr_evt) |=> irq);

  p_full_empty_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
endmodule

bind ser_fifo_ctl ser_fifo_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_wr_evt(tx_wr_evt), .tx_full(tx_full),
  .tx_empty(tx_empty), .werr_q(werr_q), .clr_evt(clr_evt),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .rx_rd_evt(rx_rd_evt),
  .rx_empty(rx_empty), .rx_push(rx_push), .rx_ie(ctrl_q[27]),
  .rx_cnt9(rx_cnt9), .rx_thr(thr_q[7:0]), .cfg_wr_evt(cfg_wr_evt), .irq(irq)
);

// File: tb/ser_fifo_ctl_tb_top.sv
module ser_fifo_ctl_tb_top;
  localparam int DEPTH = 64;
  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_CTRL = 5'h08,
                         A_STAT = 5'h0C, A_THR = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_take = 1'b0, line_busy = 1'b0;
  logic [7:0] tx_data, rx_byte = '0;
  logic rx_push = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, irq;

  int checks = 0, fails = 0;
  logic drain_en = 1'b0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] d;

  always #5 clk = ~clk;

  ser_fifo_ctl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
    .line_busy(line_busy), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: engine side of the transmit scoreboard
  always @(negedge clk) begin
    if (drain_en && tx_valid) begin
      if (txq.size() == 0) chk("R2 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 tx order", {24'h0, tx_data}, {24'h0, txq.pop_front()});
      tx_take = 1'b1;
    end else begin
      tx_take = 1'b0;
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] b, input bit expect_out);
    if (expect_out) txq.push_back(b);
    wr_reg(A_TXD, {24'h0, b});
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rd_rx_cmp(input string req);
    logic [31:0] v;
    rd(A_RXD, v);
    if (rxq.size() == 0) chk(req, v, 32'hFFFF_FFFF);
    else chk(req, v, {24'h0, rxq.pop_front()});
  endtask

  task automatic push_rx(input logic [7:0] b, input logic pe, input logic fe, input bit keep);
    if (keep) rxq.push_back(b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b; rx_par_err = pe; rx_frm_err = fe;
    @(posedge clk); #1 rx_push = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic set_drain(input logic v);
    @(posedge clk); #1 drain_en = v;
  endtask

  task automatic wait_drain();
    while (txq.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 32'h0050_0000);
    rd(A_THR, d);  chk("R1 thresholds", d, 32'h0000_2001);
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 0);

    // R2 transmit order
    set_drain(1'b1);
    for (int i = 0; i < 6; i++) wr_tx(8'h30 + 8'(i * 7), 1'b1);
    wait_drain();
    chk("R2 queue drained", txq.size(), 0);

    // R3 receive order
    push_rx(8'hA5, 0, 0, 1); push_rx(8'h5A, 0, 0, 1);
    push_rx(8'h00, 0, 0, 1); push_rx(8'hFF, 0, 0, 1);
    for (int i = 0; i < 4; i++) rd_rx_cmp("R3 rx order");

    // R4 empty read
    rd(A_RXD, d);  chk("R4 empty read value", d, 0);
    rd(A_STAT, d); chk("R4 still empty", d, 32'h0050_0000);
    push_rx(8'h77, 0, 0, 1);
    rd_rx_cmp("R4 state intact after empty read");

    // R6 busy bit and done condition
    @(negedge clk) line_busy = 1'b1;
    rd(A_STAT, d); chk("R6 busy while empty", d, 32'h0250_0000);
    @(negedge clk) line_busy = 1'b0;
    rd(A_STAT, d); chk("R6 done", d & 32'h0240_0000, 32'h0040_0000);

    // R5 full, R7 write error
    set_drain(1'b0);
    for (int i = 0; i < DEPTH; i++) wr_tx(8'(i * 3 + 1), 1'b1);
    rd(A_STAT, d); chk("R5 full flag", d, 32'h0030_0000);
    wr_tx(8'hEE, 1'b0);
    rd(A_STAT, d); chk("R7 werr set", d, 32'h0034_0000);
    repeat (4) @(posedge clk);
    set_drain(1'b1);
    wait_drain();
    rd(A_STAT, d); chk("R7 werr sticky after drain", d, 32'h0054_0000);
    wr_reg(A_CTRL, 32'h0100_0000);
    rd(A_STAT, d); chk("R7 werr cleared", d, 32'h0050_0000);
    wr_reg(A_CTRL, 32'h0);

    // R8 parity and framing flags
    push_rx(8'h11, 1, 0, 1);
    rd(A_STAT, d); chk("R8 parity flag", d, 32'h0041_0000);
    push_rx(8'h22, 0, 1, 1);
    rd(A_STAT, d); chk("R8 framing flag", d, 32'h0043_0000);
    wr_reg(A_CTRL, 32'h0100_0000);
    rd(A_STAT, d); chk("R8 flags cleared", d, 32'h0040_0000);
    wr_reg(A_CTRL, 32'h0);
    rd_rx_cmp("R8 data"); rd_rx_cmp("R8 data");

    // R9 receive overflow drops the newest byte
    for (int i = 0; i <= DEPTH; i++) push_rx(8'(i + 100), 0, 0, i < DEPTH);
    for (int i = 0; i < DEPTH; i++) rd_rx_cmp("R9 stored bytes kept");
    rd(A_STAT, d); chk("R9 empty after reads", d, 32'h0050_0000);

    // R10 receive interrupt
    wr_reg(A_THR, 32'h0000_0203);
    wr_reg(A_CTRL, 32'h0800_0000);
    push_rx(8'h01, 0, 0, 1); push_rx(8'h02, 0, 0, 1);
    chk("R10 below threshold", {31'h0, irq}, 0);
    push_rx(8'h03, 0, 0, 1);
    chk("R10 at threshold", {31'h0, irq}, 1);
    rd_rx_cmp("R10 data");
    chk("R10 below after pop", {31'h0, irq}, 0);
    rd_rx_cmp("R10 data"); rd_rx_cmp("R10 data");
    wr_reg(A_CTRL, 32'h0);

    // R11 transmit interrupt
    set_drain(1'b0);
    chk("R11 disabled", {31'h0, irq}, 0);
    wr_reg(A_CTRL, 32'h1000_0000);
    chk("R11 empty fires", {31'h0, irq}, 1);
    wr_tx(8'hC1, 1); wr_tx(8'hC2, 1);
    chk("R11 at level fires", {31'h0, irq}, 1);
    wr_tx(8'hC3, 1);
    chk("R11 above level quiet", {31'h0, irq}, 0);
    set_drain(1'b1);
    wait_drain();
    chk("R11 after drain", {31'h0, irq}, 1);
    wr_reg(A_CTRL, 32'h0);
    chk("R11 both disabled", {31'h0, irq}, 0);

    // R12 queue flush bits
    set_drain(1'b0);
    wr_tx(8'h91, 0); wr_tx(8'h92, 0); wr_tx(8'h93, 0);
    wr_reg(A_CTRL, 32'h0040_0000);
    chk("R12 tx flushed", {31'h0, tx_valid}, 0);
    wr_tx(8'h99, 0);
    rd(A_STAT, d); chk("R12 tx held empty", d, 32'h0050_0000);
    wr_reg(A_CTRL, 32'h0);
    wr_tx(8'h42, 1);
    chk("R12 tx after release", {23'h0, tx_valid, tx_data}, 32'h0000_0142);
    set_drain(1'b1);
    wait_drain();
    push_rx(8'h55, 0, 0, 0); push_rx(8'h66, 0, 0, 0);
    wr_reg(A_CTRL, 32'h0080_0000);
    push_rx(8'h67, 0, 0, 0);
    rd(A_STAT, d); chk("R12 rx flushed", d, 32'h0050_0000);
    wr_reg(A_CTRL, 32'h0);
    rd(A_RXD, d); chk("R12 rx read after flush", d, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule